// File: doc/BRIEF.md
# DMA Channel Register Bank

This block is the software-visible register front end of a multi-channel DMA engine. A host reaches it over a plain 32-bit bus made of a write strobe, a byte address, write data and read data. Most of the per-channel state sits behind one window. The host first writes a channel number into a selector register, and every later access to the channel window lands in that channel's own copy of the register. Port control works the same way through a separate port selector.

For each channel the bank keeps:
- a control word with on, transmit, reset and weight fields;
- a descriptor base address and a descriptor count;
- a polling setup;
- an interrupt status byte and an interrupt enable byte.

A global mask with one bit per channel gates the channel interrupts into a single interrupt line. A read-only identity word reports the revision, the port count and the channel count.

Two of the bits clear themselves. A channel reset takes a fixed number of cycles, and during that time its bit reads back as 1. The host can therefore poll the bit until it drops. A global reset pulse returns every channel to its reset state. The engine behind the bank consumes the per-channel on, transmit and in-reset outputs, and it reports completion events through a one-cycle event input.

Top module: `dma_reg_bank`

## Requirements
- R1: A read of offset 0x08 returns the identity word: channel count in bits 31:20, port count in bits 19:16, revision in bits 4:0 and 0 elsewhere. With the default parameters this is 0x01440003. Writes to it are ignored.
- R2: A write to offset 0x18 with a value below the channel count (20) selects that channel, and a read of 0x18 returns the selection. A write of a larger value leaves the selection unchanged.
- R3: Offsets 0x14 (poll), 0x20 (descriptor base), 0x24 (descriptor count), 0x28 (status) and 0x2C (enable) address the selected channel's own copy. Writing one channel leaves the others unchanged. Poll keeps only bit 31 (polling enable) and bit 6 (divide-by-4 clock), and all its other bits read 0.
- R4: Channel control at 0x1C keeps bit 0 (on), bit 8 (transmit) and bits 17:16 (weight), with all other bits except bit 1 reading 0. Bit 0 drives `chanOn[n]` and bit 8 drives `chanTx[n]` for channel n.
- R5: Writing 1 to control bit 1 starts a channel reset. The bit reads 1 and `chanInReset[n]` is high for 4 cycles after the write edge. At the fourth edge the reset bit, the on bit and all status bits of that channel clear.
- R6: A one-cycle event (`evtValid`, `evtChan`, `evtBits`) sets status bits in the named channel. Writing 1s to status clears those bits, so writing 0x7E clears bits 6:1. When an event and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R7: `irqOut` is high exactly when some channel n has mask bit n set and has a status bit that is set together with its enable bit.
- R8: Offset 0xF4 holds the interrupt mask, with bit n belonging to channel n. It reads back the bits that were written, for the low 20 bits only.
- R9: Writing 1 to bit 0 of offset 0x10 raises the global reset bit. The bit reads 1 for one cycle and then 0. At that edge every channel's control, poll, base, count, status and enable registers return to 0. The mask, the selectors and port control are kept.
- R10: Offset 0x40 selects a port (values below 4; larger values are ignored). Offset 0x44 addresses that port's control word, which keeps bits 11:8, 6, 5:4 and 3:2 (mask 0xF7C).
- R11: A read of an unmapped offset returns 0, and a write to one changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe, sampled at the rising edge |
| addr | input | 8 | Byte offset of the access |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr`, combinational |
| evtValid | input | 1 | One-cycle status event |
| evtChan | input | 5 | Channel the event belongs to |
| evtBits | input | 8 | Status bits the event sets |
| irqOut | output | 1 | Combined interrupt |
| chanOn | output | 20 | Per-channel on bit |
| chanTx | output | 20 | Per-channel transmit direction bit |
| chanInReset | output | 20 | Per-channel reset in progress |

## Verification
The bench counts the edges of a channel reset and samples the control word on both sides of the fourth edge. A countdown that is off by one would drop the bit a cycle early or late, and a completion that forgot the on bit or the status byte would leave them set. It writes an out-of-range channel number and an out-of-range port number and expects the old selection to survive. A bank that truncated the number instead would alias onto a low channel. It drives an event into the same status bit that a clearing write targets in the same cycle, where a design with the wrong priority would lose the event. It also toggles mask and enable bits one at a time, so that an interrupt that ignores either gate shows up.

// File: rtl/dma_bank_pkg.sv
`timescale 1ns/1ps
package dma_bank_pkg;

  // Software-visible byte offsets
  localparam logic [7:0] OFS_ID    = 8'h08;
  localparam logic [7:0] OFS_GCTRL = 8'h10;
  localparam logic [7:0] OFS_POLL  = 8'h14;
  localparam logic [7:0] OFS_CHSEL = 8'h18;
  localparam logic [7:0] OFS_CCTRL = 8'h1C;
  localparam logic [7:0] OFS_DBASE = 8'h20;
  localparam logic [7:0] OFS_DLEN  = 8'h24;
  localparam logic [7:0] OFS_ISTAT = 8'h28;
  localparam logic [7:0] OFS_IEN   = 8'h2C;
  localparam logic [7:0] OFS_PSEL  = 8'h40;
  localparam logic [7:0] OFS_PCTRL = 8'h44;
  localparam logic [7:0] OFS_IMASK = 8'hF4;

  localparam logic [31:0] PCTRL_KEEP = 32'h0000_0F7C;

  typedef enum logic [3:0] {
    RD_NONE, RD_ID, RD_GCTRL, RD_POLL, RD_CHSEL, RD_CCTRL, RD_DBASE,
    RD_DLEN, RD_ISTAT, RD_IEN, RD_PSEL, RD_PCTRL, RD_IMASK
  } rdSel_e;

  typedef struct packed {
    logic   wrGctrl;
    logic   wrPoll;
    logic   wrCctrl;
    logic   wrDbase;
    logic   wrDlen;
    logic   wrIstat;
    logic   wrIen;
    logic   wrPctrl;
    logic   wrImask;
    rdSel_e rdSel;
  } regStrobes_t;

endpackage

// File: rtl/dma_bank_ctrl.sv
`timescale 1ns/1ps
module dma_bank_ctrl
  import dma_bank_pkg::*;
#(
  parameter int NUM_CH   = 20,
  parameter int NUM_PORT = 4,
  parameter int CH_W     = 5,
  parameter int PORT_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [7:0]        addr,
  input  logic [31:0]       wrData,
  output regStrobes_t       stb,
  output logic [CH_W-1:0]   chanSel,
  output logic [PORT_W-1:0] portSel
);

  logic hitChSel, hitPortSel;

  // Decode the offset into write strobes and a read source
  always_comb begin
    stb        = '0;
    stb.rdSel  = RD_NONE;
    hitChSel   = 1'b0;
    hitPortSel = 1'b0;
    case (addr)
      OFS_ID:    stb.rdSel = RD_ID;
      OFS_GCTRL: begin stb.rdSel = RD_GCTRL; stb.wrGctrl = wrEn; end
      OFS_POLL:  begin stb.rdSel = RD_POLL;  stb.wrPoll  = wrEn; end
      OFS_CHSEL: begin stb.rdSel = RD_CHSEL; hitChSel    = wrEn; end
      OFS_CCTRL: begin stb.rdSel = RD_CCTRL; stb.wrCctrl = wrEn; end
      OFS_DBASE: begin stb.rdSel = RD_DBASE; stb.wrDbase = wrEn; end
      OFS_DLEN:  begin stb.rdSel = RD_DLEN;  stb.wrDlen  = wrEn; end
      OFS_ISTAT: begin stb.rdSel = RD_ISTAT; stb.wrIstat = wrEn; end
      OFS_IEN:   begin stb.rdSel = RD_IEN;   stb.wrIen   = wrEn; end
      OFS_PSEL:  begin stb.rdSel = RD_PSEL;  hitPortSel  = wrEn; end
      OFS_PCTRL: begin stb.rdSel = RD_PCTRL; stb.wrPctrl = wrEn; end
      OFS_IMASK: begin stb.rdSel = RD_IMASK; stb.wrImask = wrEn; end
      default:   stb.rdSel = RD_NONE;
    endcase
  end

  // Selectors accept only in-range values
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chanSel <= '0;
      portSel <= '0;
    end else begin
      if (hitChSel && (wrData < 32'(NUM_CH)))
        chanSel <= wrData[CH_W-1:0];
      if (hitPortSel && (wrData < 32'(NUM_PORT)))
        portSel <= wrData[PORT_W-1:0];
    end
  end

  p_chsel_ignore_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == OFS_CHSEL && wrData >= 32'(NUM_CH)) |=> $stable(chanSel));

  p_psel_ignore_r10: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == OFS_PSEL && wrData >= 32'(NUM_PORT)) |=> $stable(portSel));

endmodule

// File: rtl/dma_bank_data.sv
`timescale 1ns/1ps
module dma_bank_data
  import dma_bank_pkg::*;
#(
  parameter int NUM_CH     = 20,
  parameter int NUM_PORT   = 4,
  parameter int CH_W       = 5,
  parameter int PORT_W     = 2,
  parameter int IST_W      = 8,
  parameter int RST_CYCLES = 4,
  parameter int HW_REV     = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobes_t       stb,
  input  logic [CH_W-1:0]   chanSel,
  input  logic [PORT_W-1:0] portSel,
  input  logic [31:0]       wrData,
  input  logic              evtValid,
  input  logic [CH_W-1:0]   evtChan,
  input  logic [IST_W-1:0]  evtBits,
  output logic [31:0]       rdData,
  output logic              irqOut,
  output logic [NUM_CH-1:0] chanOn,
  output logic [NUM_CH-1:0] chanTx,
  output logic [NUM_CH-1:0] chanInReset
);

  localparam int CNT_W = $clog2(RST_CYCLES + 1);
  localparam logic [31:0] ID_WORD =
    {12'(NUM_CH), 4'(NUM_PORT), 11'b0, 5'(HW_REV)};

  logic                          gRst;
  logic [NUM_CH-1:0]             imask;
  logic [NUM_PORT-1:0][31:0]     pctrlQ;
  logic [NUM_CH-1:0]             onQ, txQ, rstQ, pollEnQ, pollDivQ;
  logic [NUM_CH-1:0][1:0]        wtQ;
  logic [NUM_CH-1:0][31:0]       baseQ, lenQ;
  logic [NUM_CH-1:0][IST_W-1:0]  istQ, ienQ, istNext;
  logic [NUM_CH-1:0][CNT_W-1:0]  cntQ;
  logic [NUM_CH-1:0]             rstDone, pending;

  // Status next-state: write-1-to-clear, reset completion, then event set
  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      rstDone[i] = rstQ[i] && (cntQ[i] == CNT_W'(1));
      istNext[i] = istQ[i];
      if (stb.wrIstat && chanSel == CH_W'(i))
        istNext[i] = istNext[i] & ~wrData[IST_W-1:0];
      if (rstDone[i])
        istNext[i] = '0;
      if (evtValid && evtChan == CH_W'(i))
        istNext[i] = istNext[i] | evtBits;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gRst     <= 1'b0;
      imask    <= '0;
      pctrlQ   <= '0;
      onQ      <= '0;
      txQ      <= '0;
      rstQ     <= '0;
      pollEnQ  <= '0;
      pollDivQ <= '0;
      wtQ      <= '0;
      baseQ    <= '0;
      lenQ     <= '0;
      istQ     <= '0;
      ienQ     <= '0;
      cntQ     <= '0;
    end else begin
      gRst <= stb.wrGctrl & wrData[0];
      if (stb.wrImask) imask <= wrData[NUM_CH-1:0];
      if (stb.wrPctrl) pctrlQ[portSel] <= wrData & PCTRL_KEEP;
      for (int i = 0; i < NUM_CH; i++) begin
        if (gRst) begin
          onQ[i]      <= 1'b0;
          txQ[i]      <= 1'b0;
          rstQ[i]     <= 1'b0;
          pollEnQ[i]  <= 1'b0;
          pollDivQ[i] <= 1'b0;
          wtQ[i]      <= '0;
          baseQ[i]    <= '0;
          lenQ[i]     <= '0;
          istQ[i]     <= '0;
          ienQ[i]     <= '0;
          cntQ[i]     <= '0;
        end else begin
          istQ[i] <= istNext[i];
          // reset countdown
          if (rstQ[i]) begin
            cntQ[i] <= cntQ[i] - CNT_W'(1);
            if (rstDone[i]) begin
              rstQ[i] <= 1'b0;
              onQ[i]  <= 1'b0;
            end
          end
          if (chanSel == CH_W'(i)) begin
            if (stb.wrCctrl) begin
              onQ[i] <= wrData[0];
              txQ[i] <= wrData[8];
              wtQ[i] <= wrData[17:16];
              if (wrData[1]) begin
                rstQ[i] <= 1'b1;
                cntQ[i] <= CNT_W'(RST_CYCLES);
              end
            end
            if (stb.wrPoll) begin
              pollEnQ[i]  <= wrData[31];
              pollDivQ[i] <= wrData[6];
            end
            if (stb.wrDbase) baseQ[i] <= wrData;
            if (stb.wrDlen)  lenQ[i]  <= wrData;
            if (stb.wrIen)   ienQ[i]  <= wrData[IST_W-1:0];
          end
        end
      end
    end
  end

  // Per-channel interrupt qualification
  for (genvar g = 0; g < NUM_CH; g++) begin : gChan
    assign pending[g] = imask[g] & (|(istQ[g] & ienQ[g]));

    p_rst_done_r5: assert property (@(posedge clk) disable iff (!rstN)
      ($fell(rstQ[g]) && !$past(stb.wrCctrl)) |-> !onQ[g]);
  end

  assign irqOut      = |pending;
  assign chanOn      = onQ;
  assign chanTx      = txQ;
  assign chanInReset = rstQ;

  // Read multiplexer
  always_comb begin
    case (stb.rdSel)
      RD_ID:    rdData = ID_WORD;
      RD_GCTRL: rdData = {31'b0, gRst};
      RD_POLL:  rdData = {pollEnQ[chanSel], 24'b0, pollDivQ[chanSel], 6'b0};
      RD_CHSEL: rdData = 32'(chanSel);
      RD_CCTRL: rdData = {14'b0, wtQ[chanSel], 7'b0, txQ[chanSel], 6'b0,
                          rstQ[chanSel], onQ[chanSel]};
      RD_DBASE: rdData = baseQ[chanSel];
      RD_DLEN:  rdData = lenQ[chanSel];
      RD_ISTAT: rdData = 32'(istQ[chanSel]);
      RD_IEN:   rdData = 32'(ienQ[chanSel]);
      RD_PSEL:  rdData = 32'(portSel);
      RD_PCTRL: rdData = pctrlQ[portSel];
      RD_IMASK: rdData = 32'(imask);
      default:  rdData = '0;
    endcase
  end

  p_irq_mask_r7: assert property (@(posedge clk) disable iff (!rstN)
    (imask == '0) |-> !irqOut);

  p_grst_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    (gRst && !stb.wrGctrl) |=> !gRst);

  p_grst_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    $past(gRst) |-> (onQ == '0 && rstQ == '0 && istQ == '0));

endmodule

// File: rtl/dma_reg_bank.sv
`timescale 1ns/1ps
module dma_reg_bank
  import dma_bank_pkg::*;
#(
  parameter int NUM_CH     = 20,
  parameter int NUM_PORT   = 4,
  parameter int IST_W      = 8,
  parameter int RST_CYCLES = 4,
  parameter int HW_REV     = 3,
  localparam int CH_W      = $clog2(NUM_CH),
  localparam int PORT_W    = (NUM_PORT > 1) ? $clog2(NUM_PORT) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [7:0]        addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  input  logic              evtValid,
  input  logic [CH_W-1:0]   evtChan,
  input  logic [IST_W-1:0]  evtBits,
  output logic              irqOut,
  output logic [NUM_CH-1:0] chanOn,
  output logic [NUM_CH-1:0] chanTx,
  output logic [NUM_CH-1:0] chanInReset
);

  regStrobes_t       stb;
  logic [CH_W-1:0]   chanSel;
  logic [PORT_W-1:0] portSel;

  dma_bank_ctrl #(
    .NUM_CH(NUM_CH), .NUM_PORT(NUM_PORT), .CH_W(CH_W), .PORT_W(PORT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .stb(stb), .chanSel(chanSel), .portSel(portSel)
  );

  dma_bank_data #(
    .NUM_CH(NUM_CH), .NUM_PORT(NUM_PORT), .CH_W(CH_W), .PORT_W(PORT_W),
    .IST_W(IST_W), .RST_CYCLES(RST_CYCLES), .HW_REV(HW_REV)
  ) u_data (
    .clk(clk), .rstN(rstN), .stb(stb), .chanSel(chanSel), .portSel(portSel),
    .wrData(wrData), .evtValid(evtValid), .evtChan(evtChan),
    .evtBits(evtBits), .rdData(rdData), .irqOut(irqOut), .chanOn(chanOn),
    .chanTx(chanTx), .chanInReset(chanInReset)
  );

endmodule

// File: tb/dma_reg_bank_bench.sv
`timescale 1ns/1ps
module dma_reg_bank_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        evtValid = 1'b0;
  logic [4:0]  evtChan = '0;
  logic [7:0]  evtBits = '0;
  logic        irqOut;
  logic [19:0] chanOn, chanTx, chanInReset;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  dma_reg_bank u_dma_reg_bank (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .evtValid(evtValid), .evtChan(evtChan),
    .evtBits(evtBits), .irqOut(irqOut), .chanOn(chanOn), .chanTx(chanTx),
    .chanInReset(chanInReset)
  );

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic regRead(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdData;
  endtask

  task automatic pulseEvent(input logic [4:0] ch, input logic [7:0] bits);
    @(negedge clk);
    evtValid = 1'b1; evtChan = ch; evtBits = bits;
    @(negedge clk);
    evtValid = 1'b0;
  endtask

  task automatic tResetState();
    logic [31:0] v;
    regRead(8'h1C, v); check("R4 ctrl after reset", v, 32'h0);
    regRead(8'h18, v); check("R2 chsel after reset", v, 32'h0);
    check("R7 irq after reset", 32'(irqOut), 32'h0);
    check("R4 chanOn after reset", 32'(chanOn), 32'h0);
  endtask

  task automatic tIdentity();
    logic [31:0] v;
    regRead(8'h08, v); check("R1 id word", v, 32'h0144_0003);
    regWrite(8'h08, 32'hFFFF_FFFF);
    regRead(8'h08, v); check("R1 id after write", v, 32'h0144_0003);
  endtask

  task automatic tChanSelect();
    logic [31:0] v;
    regWrite(8'h18, 32'd5);
    regRead(8'h18, v); check("R2 select 5", v, 32'd5);
    regWrite(8'h18, 32'd20);
    regRead(8'h18, v); check("R2 select 20 ignored", v, 32'd5);
    regWrite(8'h18, 32'd19);
    regRead(8'h18, v); check("R2 select 19", v, 32'd19);
  endtask

  task automatic tChanRegs();
    logic [31:0] v;
    regWrite(8'h18, 32'd2);
    regWrite(8'h20, 32'hA000_1000);
    regWrite(8'h24, 32'h0000_0040);
    regWrite(8'h14, 32'hFFFF_FFFF);
    regWrite(8'h18, 32'd3);
    regWrite(8'h20, 32'h1234_5678);
    regRead(8'h24, v); check("R3 ch3 count untouched", v, 32'h0);
    regRead(8'h14, v); check("R3 ch3 poll untouched", v, 32'h0);
    regWrite(8'h18, 32'd2);
    regRead(8'h20, v); check("R3 ch2 base", v, 32'hA000_1000);
    regRead(8'h24, v); check("R3 ch2 count", v, 32'h0000_0040);
    regRead(8'h14, v); check("R3 ch2 poll bits", v, 32'h8000_0040);
  endtask

  task automatic tCtrl();
    logic [31:0] v;
    regWrite(8'h18, 32'd7);
    regWrite(8'h1C, 32'hFFFF_FFFD);
    regRead(8'h1C, v); check("R4 ctrl kept bits", v, 32'h0003_0101);
    check("R4 chanOn[7]", 32'(chanOn), 32'h0000_0080);
    check("R4 chanTx[7]", 32'(chanTx), 32'h0000_0080);
  endtask

  task automatic tChanReset();
    logic [31:0] v;
    regWrite(8'h18, 32'd4);
    regWrite(8'h1C, 32'h1);
    pulseEvent(5'd4, 8'h08);
    regRead(8'h28, v); check("R6 status set before reset", v, 32'h08);
    regWrite(8'h1C, 32'h3);
    regRead(8'h1C, v); check("R5 reset bit set", v, 32'h3);
    repeat (3) @(negedge clk);
    regRead(8'h1C, v); check("R5 reset bit held 4th cycle", v, 32'h3);
    check("R5 chanInReset held", 32'(chanInReset), 32'h0000_0010);
    @(negedge clk);
    regRead(8'h1C, v); check("R5 reset done ctrl", v, 32'h0);
    regRead(8'h28, v); check("R5 reset cleared status", v, 32'h0);
    check("R5 chanInReset dropped", 32'(chanInReset), 32'h0);
  endtask

  task automatic tStatus();
    logic [31:0] v;
    regWrite(8'h18, 32'd6);
    pulseEvent(5'd6, 8'hFF);
    regRead(8'h28, v); check("R6 event sets", v, 32'hFF);
    regWrite(8'h28, 32'h7E);
    regRead(8'h28, v); check("R6 ack 0x7E", v, 32'h81);
    regWrite(8'h28, 32'h01);
    regRead(8'h28, v); check("R6 w1c bit0", v, 32'h80);
    pulseEvent(5'd10, 8'h01);
    regRead(8'h28, v); check("R6 other channel event", v, 32'h80);
    @(negedge clk);
    wrEn = 1'b1; addr = 8'h28; wrData = 32'h80;
    evtValid = 1'b1; evtChan = 5'd6; evtBits = 8'h80;
    @(negedge clk);
    wrEn = 1'b0; evtValid = 1'b0;
    regRead(8'h28, v); check("R6 event beats clear", v, 32'h80);
  endtask

  task automatic tIrq();
    logic [31:0] v;
    regWrite(8'h18, 32'd6);
    regWrite(8'h2C, 32'h80);
    #1 check("R7 irq masked off", 32'(irqOut), 32'h0);
    regWrite(8'hF4, 32'h0000_0040);
    regRead(8'hF4, v); check("R8 mask readback", v, 32'h40);
    check("R7 irq on", 32'(irqOut), 32'h1);
    regWrite(8'hF4, 32'h0000_0020);
    #1 check("R8 wrong channel mask", 32'(irqOut), 32'h0);
    regWrite(8'hF4, 32'hFFFF_FFFF);
    regRead(8'hF4, v); check("R8 mask width", v, 32'h000F_FFFF);
    regWrite(8'h2C, 32'h01);
    #1 check("R7 enable gates", 32'(irqOut), 32'h0);
    regWrite(8'h2C, 32'h80);
    regWrite(8'h28, 32'h80);
    #1 check("R7 irq after ack", 32'(irqOut), 32'h0);
  endtask

  task automatic tPort();
    logic [31:0] v;
    regWrite(8'h40, 32'd1);
    regWrite(8'h44, 32'hFFFF_FFFF);
    regRead(8'h44, v); check("R10 port1 ctrl bits", v, 32'h0000_0F7C);
    regWrite(8'h40, 32'd9);
    regRead(8'h40, v); check("R10 psel 9 ignored", v, 32'd1);
    regWrite(8'h40, 32'd0);
    regRead(8'h44, v); check("R10 port0 untouched", v, 32'h0);
  endtask

  task automatic tGlobalReset();
    logic [31:0] v;
    regWrite(8'hF4, 32'h0000_0040);
    regWrite(8'h18, 32'd7);
    regWrite(8'h1C, 32'h1);
    regWrite(8'h10, 32'h1);
    regRead(8'h10, v); check("R9 gctrl reads 1", v, 32'h1);
    @(negedge clk);
    regRead(8'h10, v); check("R9 gctrl self clears", v, 32'h0);
    check("R9 all channels off", 32'(chanOn), 32'h0);
    regWrite(8'h18, 32'd2);
    regRead(8'h20, v); check("R9 base cleared", v, 32'h0);
    regRead(8'h14, v); check("R9 poll cleared", v, 32'h0);
    regRead(8'hF4, v); check("R9 mask kept", v, 32'h40);
    regWrite(8'h40, 32'd1);
    regRead(8'h44, v); check("R9 port ctrl kept", v, 32'h0000_0F7C);
  endtask

  task automatic tUnmapped();
    logic [31:0] v;
    regWrite(8'h30, 32'hDEAD_BEEF);
    regRead(8'h30, v); check("R11 unmapped read", v, 32'h0);
    regRead(8'h00, v); check("R11 offset 0 read", v, 32'h0);
    regRead(8'h20, v); check("R11 base untouched", v, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tResetState();
    tIdentity();
    tChanSelect();
    tChanRegs();
    tCtrl();
    tChanReset();
    tStatus();
    tIrq();
    tPort();
    tGlobalReset();
    tUnmapped();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule